// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block raises the interrupt flags that let the two sides of a true dual-port memory signal each other. The two highest words of the array act as mailboxes. The second-highest word belongs to the left side, and the highest word belongs to the right side. When one side writes the other side's mailbox, the block raises the interrupt toward the owner of that word. The owner lowers its interrupt again by reading its own mailbox. The message word itself is held in the ordinary memory array. This block never looks at the data.

The block watches the access strobes and the address of both ports. It samples them on each rising clock edge. Every strobe is active low. Each interrupt output is active low and is driven from a flag register, so a qualifying access changes the output one clock edge later. A single enable input switches the mailbox function on or off. While it is off, the top two words are plain storage and both interrupts stay deasserted. No data moves through this block, so every pin is a plain level signal and no handshake is involved.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, `l_irq_n` and `r_irq_n` are both 1.
- R2: With `mbox_en`=1, a right-side write (`r_cs_n`=0 and `r_we_n`=0) to address 2^ADDR_W-2 drives `l_irq_n` to 0 after the next clock edge.
- R3: With `mbox_en`=1, a left-side write (`l_cs_n`=0 and `l_we_n`=0) to address 2^ADDR_W-1 drives `r_irq_n` to 0 after the next clock edge.
- R4: An access counts as a write only when chip select and write enable are both 0. A write-enable of 0 under a chip select of 1 sets no flag. A chip select of 0 with write enable 1 sets no flag. A write to any other address sets no flag.
- R5: The left side clears `l_irq_n` to 1 at the next edge with `l_cs_n`=0 and `l_oe_n`=0 at address 2^ADDR_W-2, whatever the level of `l_we_n`.
- R6: The right side clears `r_irq_n` to 1 at the next edge only by a read of address 2^ADDR_W-1 (`r_cs_n`=0, `r_oe_n`=0, `r_we_n`=1). The same access with `r_we_n`=0 leaves the flag set.
- R7: An access by the wrong side neither sets nor clears a flag. The left side writing 2^ADDR_W-2 does not assert `l_irq_n`. The right side reading 2^ADDR_W-2 does not clear it. The left side reading 2^ADDR_W-1 does not clear `r_irq_n`.
- R8: When a set and a clear of the same flag occur in the same cycle, the flag ends up set.
- R9: While `mbox_en`=0, both flags clear at the next edge and no write sets them. Raising `mbox_en` again does not bring back an old flag.
- R10: When no set, clear or disable occurs in a cycle, each interrupt output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_en | input | 1 | 1 = top two words act as mailboxes |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| l_irq_n | output | 1 | Interrupt to the left side, active low |
| r_irq_n | output | 1 | Interrupt to the right side, active low |

## Verification
The bench builds the block with ADDR_W=6, so the mailboxes sit at 0x3E and 0x3F. It places near-miss addresses such as 0x3D next to them, which lets it probe the exact address compare with a few directed accesses. The bench also drives simultaneous traffic on both sides, which exposes the set-over-clear ordering and the difference in how each side's write-enable affects a clear. It toggles the enable input while flags are pending, which shows that disabling drops the flags and that re-enabling does not restore them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_PORTS = 2;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // Active-low access strobes of one port
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
  } strobe_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0,
  parameter bit CLR_NEEDS_READ = 1'b1
) (
  input  logic              en,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_peer_wr,
  output logic              hit_own_clr
);
  logic sel;
  logic wr_q;
  logic clr_we_ok;

  assign sel  = en && !strb.cs_n;
  assign wr_q = sel && !strb.we_n;

  generate
    if (CLR_NEEDS_READ) begin : g_rd_only
      assign clr_we_ok = strb.we_n;
    end else begin : g_any_we
      assign clr_we_ok = 1'b1;
    end
  endgenerate

  assign hit_peer_wr = wr_q && (addr == PEER_BOX);
  assign hit_own_clr = sel && !strb.oe_n && clr_we_ok && (addr == OWN_BOX);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (!en)    flag <= 1'b0;
    else if (set)    flag <= 1'b1;  // set has priority over clear
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_HI = '1;
  localparam logic [ADDR_W-1:0] BOX_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

  strobe_t           strb  [NUM_PORTS];
  logic [ADDR_W-1:0] addr  [NUM_PORTS];
  logic              wr_pk [NUM_PORTS];
  logic              clr_o [NUM_PORTS];
  logic              flag  [NUM_PORTS];

  assign strb[SIDE_L] = '{cs_n: l_cs_n, we_n: l_we_n, oe_n: l_oe_n};
  assign strb[SIDE_R] = '{cs_n: r_cs_n, we_n: r_we_n, oe_n: r_oe_n};
  assign addr[SIDE_L] = l_addr;
  assign addr[SIDE_R] = r_addr;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_side
      mbx_port_decode #(
        .ADDR_W        (ADDR_W),
        .OWN_BOX       ((p == 0) ? BOX_LO : BOX_HI),
        .PEER_BOX      ((p == 0) ? BOX_HI : BOX_LO),
        .CLR_NEEDS_READ((p == 0) ? 1'b0 : 1'b1)
      ) u_dec (
        .en         (mbox_en),
        .strb       (strb[p]),
        .addr       (addr[p]),
        .hit_peer_wr(wr_pk[p]),
        .hit_own_clr(clr_o[p])
      );

      mbx_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (mbox_en),
        .set  (wr_pk[NUM_PORTS-1-p]),
        .clr  (clr_o[p]),
        .flag (flag[p])
      );
    end
  endgenerate

  assign l_irq_n = ~flag[SIDE_L];
  assign r_irq_n = ~flag[SIDE_R];
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_en,
  input logic              l_cs_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] HI = '1;
  localparam logic [ADDR_W-1:0] LO = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic set_l, set_r, clr_l, clr_r;
  assign set_l = mbox_en && !r_cs_n && !r_we_n && r_addr == LO;
  assign set_r = mbox_en && !l_cs_n && !l_we_n && l_addr == HI;
  assign clr_l = mbox_en && !l_cs_n && !l_oe_n && l_addr == LO;
  assign clr_r = mbox_en && !r_cs_n && !r_oe_n && r_we_n && r_addr == HI;

  assert_left_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> !l_irq_n);
  assert_right_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_r |=> !r_irq_n);
  assert_left_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> l_irq_n);
  assert_right_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> r_irq_n);
  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> (l_irq_n && r_irq_n));
  assert_hold_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !set_l && !clr_l && $past(rst_n)) |=> $stable(l_irq_n));
  assert_hold_right_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !set_r && !clr_r && $past(rst_n)) |=> $stable(r_irq_n));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
  .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
  .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbx_irq_ctrl_bench.sv
module mbx_irq_ctrl_bench;
  localparam int AW = 6;
  localparam logic [AW-1:0] HI = 6'h3F;
  localparam logic [AW-1:0] LO = 6'h3E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbox_en = 1'b1;
  logic l_cs_n = 1, l_we_n = 1, l_oe_n = 1;
  logic r_cs_n = 1, r_we_n = 1, r_oe_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW)) u_mbx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive one access on each side for one cycle,
  // let the rising edge take it, return idle at the next falling edge.
  task automatic access(input logic lc, input logic lw, input logic lo, input logic [AW-1:0] la,
                        input logic rc, input logic rw, input logic ro, input logic [AW-1:0] ra);
    l_cs_n = lc; l_we_n = lw; l_oe_n = lo; l_addr = la;
    r_cs_n = rc; r_we_n = rw; r_oe_n = ro; r_addr = ra;
    @(posedge clk);
    @(negedge clk);
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1;
  endtask

  task automatic idle_cycle();
    access(1, 1, 1, '0, 1, 1, 1, '0);
  endtask

  task automatic t_reset();
    chk("R1 l_irq_n", l_irq_n, 1'b1);
    chk("R1 r_irq_n", r_irq_n, 1'b1);
  endtask

  task automatic t_qualify();
    access(1, 1, 1, '0, 1, 0, 1, LO);      // cs high
    chk("R4 cs high", l_irq_n, 1'b1);
    access(1, 1, 1, '0, 0, 1, 1, LO);      // we high
    chk("R4 we high", l_irq_n, 1'b1);
    access(1, 1, 1, '0, 0, 0, 1, 6'h3D);   // other address
    chk("R4 near addr", l_irq_n, 1'b1);
    access(0, 0, 1, LO, 1, 1, 1, '0);      // left writes own box
    chk("R7 own write", l_irq_n, 1'b1);
  endtask

  task automatic t_left_path();
    access(1, 1, 1, '0, 0, 0, 1, LO);
    chk("R2 set", l_irq_n, 1'b0);
    chk("R2 other flag", r_irq_n, 1'b1);
    idle_cycle();
    chk("R10 hold", l_irq_n, 1'b0);
    access(1, 1, 1, '0, 0, 1, 0, LO);      // right reads left box
    chk("R7 wrong side read", l_irq_n, 1'b0);
    access(0, 1, 0, HI, 1, 1, 1, '0);      // left reads other box
    chk("R7 wrong box", l_irq_n, 1'b0);
    access(0, 0, 0, LO, 1, 1, 1, '0);      // we low still clears
    chk("R5 clear we low", l_irq_n, 1'b1);
    access(1, 1, 1, '0, 0, 0, 1, LO);
    access(0, 1, 0, LO, 1, 1, 1, '0);
    chk("R5 clear read", l_irq_n, 1'b1);
  endtask

  task automatic t_right_path();
    access(0, 0, 1, HI, 1, 1, 1, '0);
    chk("R3 set", r_irq_n, 1'b0);
    chk("R3 other flag", l_irq_n, 1'b1);
    access(1, 1, 1, '0, 0, 0, 0, HI);      // we low: no clear
    chk("R6 we low", r_irq_n, 1'b0);
    access(1, 1, 1, '0, 0, 1, 0, HI);
    chk("R6 clear", r_irq_n, 1'b1);
  endtask

  task automatic t_set_wins();
    access(0, 1, 0, LO, 0, 0, 1, LO);      // clear and set together
    chk("R8 from clear", l_irq_n, 1'b0);
    access(0, 1, 0, LO, 0, 0, 1, LO);
    chk("R8 from set", l_irq_n, 1'b0);
  endtask

  task automatic t_disable();
    access(0, 0, 1, HI, 0, 0, 1, LO);
    chk("R9 pre l", l_irq_n, 1'b0);
    chk("R9 pre r", r_irq_n, 1'b0);
    mbox_en = 1'b0;
    idle_cycle();
    chk("R9 drop l", l_irq_n, 1'b1);
    chk("R9 drop r", r_irq_n, 1'b1);
    access(0, 0, 1, HI, 0, 0, 1, LO);
    chk("R9 no set l", l_irq_n, 1'b1);
    chk("R9 no set r", r_irq_n, 1'b1);
    mbox_en = 1'b1;
    idle_cycle();
    chk("R9 no return", l_irq_n & r_irq_n, 1'b1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qualify();
    t_left_path();
    t_right_path();
    t_set_wins();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule